// File: doc/BRIEF.md
# Shared Reset Line Sequencer

This block owns the enable of an open-drain system reset line that other agents on the board may also pull low. After power comes up, the line is held low until the clock source reports lock and a full drive window has passed after lock. An internal reset request started from the idle state also holds the line low for at least one full drive window, and longer while the request stays high. When a drive window ends, the line is released for a fixed settling interval. The line level is then judged. A high level ends the sequence. A low level means another agent still holds reset, so the block drives a fresh window and tries again.

Alongside the line enable, the block supplies a module reset for on-chip logic and a single-cycle pulse that tells the rest of the chip to begin reset processing. The power-on indication is the block's own asynchronous reset. The line level arrives as a raw input and passes through a synchronizer before it is judged.

Top module: `rst_pin_seq`

## Requirements
- R1: While `por_i` is high, and after it falls until `pll_lock_i` has been seen high at a clock edge, `pin_drv_o` and `mod_rst_o` are 1 and `start_pulse_o` is 0.
- R2: From the first edge that samples `pll_lock_i` high after power-on, `pin_drv_o` stays 1 for exactly DRIVE_CYC (default 512) cycles and then falls to 0.
- R3: An internal request sampled high in the idle state starts a drive. A request held for R cycles gives a first drive of max(DRIVE_CYC, R) cycles. `pin_drv_o`=1 means the line is pulled low.
- R4: After a drive ends, `pin_drv_o` stays 0 for exactly SETTLE_CYC (default 10) cycles. If the line is judged high, `start_pulse_o` is 1 in the next cycle, which is SETTLE_CYC cycles after the drive fell.
- R5: If the line is judged low (`pin_i`=0), a new drive of exactly DRIVE_CYC cycles starts. It is followed by another settling interval and judgement, and this repeats until the line is judged high.
- R6: `pin_i` passes through a two-stage synchronizer. The judged level is the one `pin_i` had at the clock edge two cycles before the end of the settling interval (the 8th edge of the release with defaults).
- R7: `mod_rst_o` is 1 whenever the line is driven or the settling interval runs. It is 0 in the cycle of `start_pulse_o` and stays asserted for at least MODRST_MIN (default 4) clocked cycles each time it rises.
- R8: `start_pulse_o` lasts one cycle and occurs once per sequence. Afterwards the block idles with `pin_drv_o`=0 and `mod_rst_o`=0, and `pin_i` has no effect until a new request arrives.
- R9: An internal request sampled high during the settling interval aborts it and restarts a full drive of DRIVE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous reset of the block |
| int_req_i | input | 1 | Internal reset request, active high |
| pll_lock_i | input | 1 | Clock source lock flag, active high |
| pin_i | input | 1 | Raw level of the shared reset line (1 = high) |
| pin_drv_o | output | 1 | 1 = pull the reset line low, 0 = leave it undriven |
| mod_rst_o | output | 1 | Module reset for on-chip logic, active high |
| start_pulse_o | output | 1 | One-cycle pulse that starts reset processing |

## Verification
Several properties are checked on every cycle. A drive never ends before DRIVE_CYC cycles have passed. Every start pulse comes after exactly SETTLE_CYC released cycles. The pulse never lasts two cycles. The module reset covers every driven cycle and is never shorter than MODRST_MIN. Before lock, the line stays driven. Only the bench scenarios can show the exact drive lengths: max(DRIVE_CYC, R) for a held request, whole extra windows added by an external holder, the one-cycle boundary of the synchronized judgement, the abort of a settling interval, and the line level being ignored while idle.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [2:0] {
        ST_PWR     = 3'd0,
        ST_DRIVE   = 3'd1,
        ST_RELEASE = 3'd2,
        ST_START   = 3'd3,
        ST_IDLE    = 3'd4
    } rps_state_e;

    typedef struct packed {
        rps_state_e state;
    } rps_fsm_t;

    localparam int unsigned RPS_DRIVE_CYC  = 512;
    localparam int unsigned RPS_SETTLE_CYC = 10;
    localparam int unsigned RPS_MODRST_MIN = 4;
    localparam int unsigned RPS_SYNC_STG   = 2;

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rps_window_cnt.sv
module rps_window_cnt #(
    parameter int unsigned DRIVE_CYC  = 512,
    parameter int unsigned SETTLE_CYC = 10,
    parameter int unsigned CNT_W      = $clog2(DRIVE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic drive_done_o,
    output logic settle_done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d.cnt = '0;
        else if (run_i) cnt_d.cnt = cnt_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign drive_done_o  = (cnt_q.cnt == DRIVE_LAST);
    assign settle_done_o = (cnt_q.cnt == SETTLE_LAST);
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
    import rps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic int_req_i,
    input  logic pll_lock_i,
    input  logic pin_high_i,
    input  logic drive_done_i,
    input  logic settle_done_i,
    output logic cnt_clr_o,
    output logic cnt_run_o,
    output logic drive_o,
    output logic busy_o,
    output logic pulse_o
);
    rps_fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_PWR: begin
                if (pll_lock_i) fsm_d.state = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (drive_done_i && !int_req_i) fsm_d.state = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (int_req_i)          fsm_d.state = ST_DRIVE;
                else if (settle_done_i) fsm_d.state = pin_high_i ? ST_START : ST_DRIVE;
            end
            ST_START: begin
                fsm_d.state = int_req_i ? ST_DRIVE : ST_IDLE;
            end
            ST_IDLE: begin
                if (int_req_i) fsm_d.state = ST_DRIVE;
            end
            default: fsm_d.state = ST_PWR;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) fsm_q <= '{state: ST_PWR};
        else     fsm_q <= fsm_d;
    end

    assign cnt_clr_o = (fsm_d.state != fsm_q.state);
    assign cnt_run_o = ((fsm_q.state == ST_DRIVE) && !drive_done_i)
                     || (fsm_q.state == ST_RELEASE);
    assign drive_o   = (fsm_q.state == ST_PWR) || (fsm_q.state == ST_DRIVE);
    assign busy_o    = drive_o || (fsm_q.state == ST_RELEASE);
    assign pulse_o   = (fsm_q.state == ST_START);
endmodule

// File: rtl/rps_rst_stretch.sv
module rps_rst_stretch #(
    parameter int unsigned MIN_CYC = 4,
    parameter int unsigned AGE_W   = $clog2(MIN_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    output logic mod_rst_o
);
    typedef struct packed {
        logic [AGE_W-1:0] age;
    } age_t;

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MIN_CYC);

    age_t age_d, age_q;
    logic hold;

    always_comb begin
        hold      = (age_q.age != '0) && (age_q.age < AGE_MAX);
        mod_rst_o = busy_i || hold;
        age_d     = age_q;
        if (!mod_rst_o)              age_d.age = '0;
        else if (age_q.age < AGE_MAX) age_d.age = age_q.age + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) age_q <= '0;
        else     age_q <= age_d;
    end
endmodule

// File: rtl/rst_pin_seq.sv
module rst_pin_seq
    import rps_pkg::*;
#(
    parameter int unsigned DRIVE_CYC  = RPS_DRIVE_CYC,
    parameter int unsigned SETTLE_CYC = RPS_SETTLE_CYC,
    parameter int unsigned MODRST_MIN = RPS_MODRST_MIN,
    parameter int unsigned SYNC_STG   = RPS_SYNC_STG
) (
    input  logic clk,
    input  logic por_i,
    input  logic int_req_i,
    input  logic pll_lock_i,
    input  logic pin_i,
    output logic pin_drv_o,
    output logic mod_rst_o,
    output logic start_pulse_o
);
    localparam int unsigned WIN_MAX = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
    localparam int unsigned CNT_W   = $clog2(WIN_MAX + 1);

    logic pin_sync;
    logic cnt_clr, cnt_run;
    logic drive_done, settle_done;
    logic busy;

    rps_sync #(
        .STAGES (SYNC_STG),
        .RST_VAL(1'b0)
    ) u_sync (
        .clk    (clk),
        .rst    (por_i),
        .async_i(pin_i),
        .sync_o (pin_sync)
    );

    rps_window_cnt #(
        .DRIVE_CYC (DRIVE_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst          (por_i),
        .clr_i        (cnt_clr),
        .run_i        (cnt_run),
        .drive_done_o (drive_done),
        .settle_done_o(settle_done)
    );

    rps_fsm u_fsm (
        .clk          (clk),
        .rst          (por_i),
        .int_req_i    (int_req_i),
        .pll_lock_i   (pll_lock_i),
        .pin_high_i   (pin_sync),
        .drive_done_i (drive_done),
        .settle_done_i(settle_done),
        .cnt_clr_o    (cnt_clr),
        .cnt_run_o    (cnt_run),
        .drive_o      (pin_drv_o),
        .busy_o       (busy),
        .pulse_o      (start_pulse_o)
    );

    rps_rst_stretch #(
        .MIN_CYC(MODRST_MIN)
    ) u_stretch (
        .clk      (clk),
        .rst      (por_i),
        .busy_i   (busy),
        .mod_rst_o(mod_rst_o)
    );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int unsigned DRIVE_CYC  = 512,
    parameter int unsigned SETTLE_CYC = 10,
    parameter int unsigned MODRST_MIN = 4
) (
    input logic clk,
    input logic por_i,
    input logic pll_lock_i,
    input logic pin_drv_o,
    input logic mod_rst_o,
    input logic start_pulse_o
);
    localparam int unsigned SAT = 32'h0000_FFFF;

    int unsigned hirun_q, lowrun_q, rstrun_q;
    logic        lock_seen_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            hirun_q     <= 0;
            lowrun_q    <= 0;
            rstrun_q    <= 0;
            lock_seen_q <= 1'b0;
        end else begin
            hirun_q     <= pin_drv_o ? ((hirun_q < SAT) ? hirun_q + 1 : SAT) : 0;
            lowrun_q    <= !pin_drv_o ? ((lowrun_q < SAT) ? lowrun_q + 1 : SAT) : 0;
            rstrun_q    <= mod_rst_o ? ((rstrun_q < SAT) ? rstrun_q + 1 : SAT) : 0;
            lock_seen_q <= lock_seen_q || pll_lock_i;
        end
    end

    // R1
    lock_wait_chk: assert property (@(posedge clk) disable iff (por_i)
        !lock_seen_q |-> (pin_drv_o && mod_rst_o && !start_pulse_o));

    // R3
    drive_min_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(pin_drv_o) |-> (hirun_q >= DRIVE_CYC));

    // R4
    release_len_chk: assert property (@(posedge clk) disable iff (por_i)
        start_pulse_o |-> (lowrun_q == SETTLE_CYC));

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (por_i)
        start_pulse_o |=> !start_pulse_o);

    // R7
    rst_cover_chk: assert property (@(posedge clk) disable iff (por_i)
        pin_drv_o |-> mod_rst_o);

    // R7
    rst_off_chk: assert property (@(posedge clk) disable iff (por_i)
        start_pulse_o |-> !mod_rst_o);

    // R7
    rst_min_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(mod_rst_o) |-> (rstrun_q >= MODRST_MIN));
endmodule

bind rst_pin_seq rps_checker #(
    .DRIVE_CYC (DRIVE_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .MODRST_MIN(MODRST_MIN)
) u_chk (
    .clk          (clk),
    .por_i        (por_i),
    .pll_lock_i   (pll_lock_i),
    .pin_drv_o    (pin_drv_o),
    .mod_rst_o    (mod_rst_o),
    .start_pulse_o(start_pulse_o)
);

// File: tb/sim_rst_pin_seq.sv
`timescale 1ns/1ps
module sim_rst_pin_seq;
    localparam int DRV = 512;
    localparam int STL = 10;
    localparam int NVEC = 6;
    // each row: {request cycles R, external hold cycles H}
    localparam int VEC [NVEC][2] = '{
        '{1, 0}, '{600, 0}, '{1, 520}, '{1, 521}, '{1, 1100}, '{700, 1300}
    };

    logic clk = 1'b0;
    logic por_i = 1'b1;
    logic int_req_i = 1'b0;
    logic pll_lock_i = 1'b0;
    logic ext_hold = 1'b0;
    logic pin_i;
    logic pin_drv_o, mod_rst_o, start_pulse_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign pin_i = !(pin_drv_o || ext_hold);

    rst_pin_seq u0 (
        .clk          (clk),
        .por_i        (por_i),
        .int_req_i    (int_req_i),
        .pll_lock_i   (pll_lock_i),
        .pin_i        (pin_i),
        .pin_drv_o    (pin_drv_o),
        .mod_rst_o    (mod_rst_o),
        .start_pulse_o(start_pulse_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts a sequence (by request, or by lock when by_lock) and observes it.
    task automatic run_seq(input int r, input int h, input bit by_lock,
                           output int drv_n, output int win_n,
                           output int pulse_c, output int pulse_n,
                           output int rst_at);
        logic prev;
        drv_n = 0; win_n = 0; pulse_c = -1; pulse_n = 0; rst_at = -1;
        @(negedge clk);
        prev = pin_drv_o;
        if (by_lock) pll_lock_i = 1'b1;
        else         int_req_i = (r > 0);
        ext_hold = (h > 0);
        for (int c = 1; c < 8000; c++) begin
            @(negedge clk);
            if (pin_drv_o) drv_n++;
            if (pin_drv_o && !prev) win_n++;
            prev = pin_drv_o;
            if (start_pulse_o) begin
                pulse_n++;
                if (pulse_c < 0) begin
                    pulse_c = c - 1;
                    rst_at = mod_rst_o;
                end
            end
            int_req_i = (c < r);
            ext_hold = (c < h);
            if (pulse_c >= 0 && c >= pulse_c + 20) break;
        end
    endtask

    initial begin
        int drv_n, win_n, pulse_c, pulse_n, rst_at;
        int l1, n, r, h;

        // R1: power-on state
        repeat (5) @(negedge clk);
        check("R1 drive during por", pin_drv_o, 1);
        check("R1 mod_rst during por", mod_rst_o, 1);
        check("R1 no pulse during por", start_pulse_o, 0);
        por_i = 1'b0;
        repeat (100) @(negedge clk);
        check("R1 drive before lock", pin_drv_o, 1);
        check("R1 mod_rst before lock", mod_rst_o, 1);

        // R2: drive after lock
        run_seq(0, 0, 1'b1, drv_n, win_n, pulse_c, pulse_n, rst_at);
        check("R2 drive cycles after lock", drv_n, DRV);
        check("R2 pulse time after lock", pulse_c, DRV + STL);

        // R3 R4 R5 R6 R7 R8: vector table
        for (int v = 0; v < NVEC; v++) begin
            r = VEC[v][0];
            h = VEC[v][1];
            l1 = (r > DRV) ? r : DRV;
            n = 1;
            while (l1 + (DRV + STL) * (n - 1) + (STL - 2) < h) n++;
            run_seq(r, h, 1'b0, drv_n, win_n, pulse_c, pulse_n, rst_at);
            check("R3 R5 drive cycles", drv_n, l1 + DRV * (n - 1));
            check("R5 drive windows", win_n, n);
            check("R4 R6 pulse time", pulse_c, l1 + (DRV + STL) * (n - 1) + STL);
            check("R8 single pulse", pulse_n, 1);
            check("R7 mod_rst low at pulse", rst_at, 0);
        end

        // R8: idle ignores the line level
        begin
            int bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                ext_hold = k[0];
                if (pin_drv_o || start_pulse_o || mod_rst_o) bad++;
            end
            ext_hold = 1'b0;
            check("R8 idle outputs quiet", bad, 0);
        end

        // R9: request during settling aborts it
        begin
            int pulses = 0;
            int run = 0;
            int gap = 0;
            @(negedge clk);
            int_req_i = 1'b1;
            @(negedge clk);
            int_req_i = 1'b0;
            while (pin_drv_o) @(negedge clk);
            repeat (3) begin
                if (start_pulse_o) pulses++;
                @(negedge clk);
            end
            int_req_i = 1'b1;
            @(negedge clk);
            int_req_i = 1'b0;
            while (pin_drv_o) begin
                run++;
                @(negedge clk);
            end
            while (!start_pulse_o && gap < 100) begin
                gap++;
                @(negedge clk);
            end
            if (start_pulse_o) pulses++;
            check("R9 restarted drive length", run, DRV);
            check("R9 settle after restart", gap, STL);
            check("R9 one pulse for aborted sequence", pulses, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule